// File: doc/BRIEF.md
# Cascadable LED driver serial interface

This block is the serial input side of one dot-matrix LED driver that can be chained with identical drivers. A host shifts one bit per shift strobe through `din_i` while `ce_ni` is low. `rs_i` steers the bit into either a dot shift register or an 8-bit control shift register. When `ce_ni` rises after a control write, the shifted byte moves into control word 0 or control word 1. Bit 7 of the byte selects which word receives it.

Control word 1 has two fields. Bit 0 sets how `dout_o` behaves during control writes. In serial mode (0) a chain of N drivers acts as one long 8N-bit shift register. In simultaneous mode (1) `dout_o` copies `din_i`, so one set of 8 strobes loads every driver in the chain. Bit 1 selects the display clock source: either every external oscillator tick, or every eighth tick. A 9-bit counter of display ticks flags each completed 512-tick refresh.

Top module: `led_ser_if`

## Requirements
- R1: While `ce_ni` is low and `rs_i` is low, each `sclk_i` strobe shifts `din_i` into bit 0 of the dot register, and every other bit moves up one place. `dot_o` shows the register. While `rs_i` is low, `dout_o` shows the top dot bit (bit DOT_BITS-1).
- R2: In serial mode (control word 1 bit 0 = 0), each control strobe shifts `din_i` into bit 0 of the control shift register. While `rs_i` is high, `dout_o` shows bit 7 of that register, which is the bit shifted in 8 strobes earlier.
- R3: In simultaneous mode (control word 1 bit 0 = 1), while `ce_ni` is low and `rs_i` is high, `dout_o` equals `din_i` in the same cycle.
- R4: `ce_ni` may rise after at least one control strobe. If shifted bit 7 is 0, the byte loads into `ctrl0_o`; if it is 1, the byte loads into `ctrl1_o`. Both are visible the cycle after the rise. A rise that follows only dot strobes changes neither word.
- R5: `rst_ni` low clears the dot register, the control shift register, `ctrl0_o`, `ctrl1_o`, the prescale divider and the refresh counter. This leaves serial mode with no prescale.
- R6: When control word 1 bit 1 = 0, `disp_tick_o` equals `osc_tick_i`. When it is 1, `disp_tick_o` goes high on every eighth `osc_tick_i` after the bit was set. A tick in the same cycle as the latch that sets the bit still passes directly.
- R7: `refresh_done_o` is high for exactly one cycle, the cycle after the display tick that wraps the 9-bit counter from 511 to 0. With prescale on and ticks arriving every cycle, this takes 4096 oscillator ticks.
- R8: A strobe while `ce_ni` is high shifts neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Active-low chip enable; rising edge latches a control byte |
| rs_i | input | 1 | Register select: 0 dot, 1 control |
| sclk_i | input | 1 | Shift strobe, one bit per cycle high |
| din_i | input | 1 | Serial data in |
| osc_tick_i | input | 1 | External oscillator tick strobe |
| dout_o | output | 1 | Serial data out to the next driver |
| dot_o | output | DOT_BITS | Dot register contents |
| ctrl0_o | output | 8 | Control word 0 |
| ctrl1_o | output | 8 | Control word 1 (bit 0 simultaneous mode, bit 1 prescale, bit 7 = 1) |
| disp_tick_o | output | 1 | Display clock tick |
| refresh_done_o | output | 1 | One-cycle refresh-complete pulse |

## Verification
Two functions can fall in the same cycle: the chip-enable rise that latches the prescale bit, and an oscillator tick. The bench raises `ce_ni` and `osc_tick_i` together. It expects that tick to pass straight through as a display tick and to count once toward the refresh. After that, display ticks must arrive every eighth oscillator tick. The refresh pulse must appear 4088 ticks later, not 4096. A miscount of the boundary tick shifts both the tick phase and the pulse cycle, so the bench reports it.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic       sel;       // 1 = word 1
    logic [4:0] rsvd;
    logic       prescale;
    logic       sim_mode;
  } ctrl1_t;
endpackage

// File: rtl/led_ser_shift.sv
module led_ser_shift #(
  parameter int DOT_BITS = 160
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             shift_en_i,
  input  logic                             rs_i,
  input  logic                             din_i,
  input  logic                             sim_mode_i,
  output logic [DOT_BITS-1:0]              dot_o,
  output logic [led_ser_pkg::CTRL_W-1:0]   ctrl_sr_o,
  output logic                             ctrl_shift_o,
  output logic                             dout_o
);
  import led_ser_pkg::*;

  logic [DOT_BITS-1:0] dot_q;
  logic [CTRL_W-1:0]   ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      ctrl_q <= '0;
    end else if (shift_en_i) begin
      if (rs_i) ctrl_q <= {ctrl_q[CTRL_W-2:0], din_i};
      else      dot_q  <= {dot_q[DOT_BITS-2:0], din_i};
    end
  end

  always_comb begin
    if (!rs_i)          dout_o = dot_q[DOT_BITS-1];
    else if (sim_mode_i) dout_o = din_i;
    else                dout_o = ctrl_q[CTRL_W-1];
  end

  assign dot_o        = dot_q;
  assign ctrl_sr_o    = ctrl_q;
  assign ctrl_shift_o = shift_en_i & rs_i;
endmodule

// File: rtl/led_ser_ctrl.sv
module led_ser_ctrl (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ce_ni,
  input  logic                           ctrl_shift_i,
  input  logic [led_ser_pkg::CTRL_W-1:0] ctrl_sr_i,
  output logic [led_ser_pkg::CTRL_W-1:0] ctrl0_o,
  output led_ser_pkg::ctrl1_t            ctrl1_o
);
  import led_ser_pkg::*;

  logic ce_q, pend_q, ce_rise;

  assign ce_rise = ce_ni & ~ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= 1'b1;
      pend_q  <= 1'b0;
      ctrl0_o <= '0;
      ctrl1_o <= '0;
    end else begin
      ce_q <= ce_ni;
      if (ctrl_shift_i) pend_q <= 1'b1;
      if (ce_rise) begin
        pend_q <= 1'b0;
        if (pend_q) begin
          if (ctrl_sr_i[CTRL_W-1]) ctrl1_o <= ctrl1_t'(ctrl_sr_i);
          else                     ctrl0_o <= ctrl_sr_i;
        end
      end
    end
  end
endmodule

// File: rtl/led_ser_dispclk.sv
module led_ser_dispclk #(
  parameter int PRESCALE = 8,
  parameter int REFRESH  = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic prescale_i,
  output logic disp_tick_o,
  output logic refresh_done_o
);
  localparam int DIV_W = $clog2(PRESCALE);
  localparam int REF_W = $clog2(REFRESH);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REFRESH - 1);

  logic [DIV_W-1:0] div_q;
  logic [REF_W-1:0] ref_q;

  assign disp_tick_o = osc_tick_i & (~prescale_i | (div_q == DIV_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q          <= '0;
      ref_q          <= '0;
      refresh_done_o <= 1'b0;
    end else begin
      if (!prescale_i)     div_q <= '0;
      else if (osc_tick_i) div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      if (disp_tick_o)     ref_q <= (ref_q == REF_LAST) ? '0 : ref_q + 1'b1;
      refresh_done_o <= disp_tick_o & (ref_q == REF_LAST);
    end
  end
endmodule

// File: rtl/led_ser_if.sv
module led_ser_if #(
  parameter int DOT_BITS = 160,
  parameter int PRESCALE = 8,
  parameter int REFRESH  = 512
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_ni,
  input  logic                rs_i,
  input  logic                sclk_i,
  input  logic                din_i,
  input  logic                osc_tick_i,
  output logic                dout_o,
  output logic [DOT_BITS-1:0] dot_o,
  output logic [7:0]          ctrl0_o,
  output logic [7:0]          ctrl1_o,
  output logic                disp_tick_o,
  output logic                refresh_done_o
);
  import led_ser_pkg::*;

  logic              shift_en, ctrl_shift;
  logic [CTRL_W-1:0] ctrl_sr;
  ctrl1_t            ctrl1;

  assign shift_en = sclk_i & ~ce_ni;   // strobes ignored while deselected

  led_ser_shift #(.DOT_BITS(DOT_BITS)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .shift_en_i   (shift_en),
    .rs_i         (rs_i),
    .din_i        (din_i),
    .sim_mode_i   (ctrl1.sim_mode),
    .dot_o        (dot_o),
    .ctrl_sr_o    (ctrl_sr),
    .ctrl_shift_o (ctrl_shift),
    .dout_o       (dout_o)
  );

  led_ser_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_ni        (ce_ni),
    .ctrl_shift_i (ctrl_shift),
    .ctrl_sr_i    (ctrl_sr),
    .ctrl0_o      (ctrl0_o),
    .ctrl1_o      (ctrl1)
  );

  led_ser_dispclk #(.PRESCALE(PRESCALE), .REFRESH(REFRESH)) u_clk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .osc_tick_i     (osc_tick_i),
    .prescale_i     (ctrl1.prescale),
    .disp_tick_o    (disp_tick_o),
    .refresh_done_o (refresh_done_o)
  );

  assign ctrl1_o = ctrl1;
endmodule

// File: rtl/led_ser_if_chk.sv
module led_ser_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       rs_i,
  input logic       din_i,
  input logic       osc_tick_i,
  input logic       dout_o,
  input logic [7:0] ctrl0_o,
  input logic [7:0] ctrl1_o,
  input logic       disp_tick_o,
  input logic       refresh_done_o
);
  logic [3:0] oc_q;   // osc ticks since last display tick
  logic [9:0] dc_q;   // display ticks since last refresh pulse

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q <= '0;
      dc_q <= '0;
    end else begin
      if (!ctrl1_o[1] || disp_tick_o) oc_q <= '0;
      else if (osc_tick_i)            oc_q <= oc_q + 4'd1;
      if (refresh_done_o) dc_q <= disp_tick_o ? 10'd1 : 10'd0;
      else if (disp_tick_o) dc_q <= dc_q + 10'd1;
    end
  end

  a_r3_sim_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && rs_i && ctrl1_o[0]) |-> (dout_o == din_i));

  a_r4_latch_on_ce_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ctrl0_o) || !$stable(ctrl1_o)) |-> ($past(ce_ni) && !$past(ce_ni, 2)));

  a_r6_prescale_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_tick_o && ctrl1_o[1]) |-> (oc_q == 4'd7));

  a_r7_refresh_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_done_o |-> (dc_q == 10'd512));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_done_o |=> !refresh_done_o);
endmodule

bind led_ser_if led_ser_if_chk u_chk (.*);

// File: tb/led_ser_if_tb.sv
module led_ser_if_tb;
  localparam int DOT = 160;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ce_n = 1'b1, rs = 1'b0, sclk = 1'b0, din = 1'b0, osc = 1'b0;
  logic           dout, disp_tick, done;
  logic [DOT-1:0] dot;
  logic [7:0]     c0, c1;

  led_ser_if #(.DOT_BITS(DOT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rs_i(rs), .sclk_i(sclk),
    .din_i(din), .osc_tick_i(osc), .dout_o(dout), .dot_o(dot),
    .ctrl0_o(c0), .ctrl1_o(c1), .disp_tick_o(disp_tick), .refresh_done_o(done)
  );

  int n_chk = 0, n_bad = 0;
  logic  exp_q[$];
  string req_q[$];
  logic  mon_en = 1'b0;

  logic [DOT-1:0] dot_m;
  logic [7:0]     ctl_m;
  logic           sim_m;

  task automatic check(input string req, input logic [DOT-1:0] act, input logic [DOT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: compares dout against expected stream
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      logic  e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(r, {{(DOT-1){1'b0}}, dout}, {{(DOT-1){1'b0}}, e});
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; rs = 1'b0; sclk = 1'b0; din = 1'b0; osc = 1'b0;
    dot_m = '0; ctl_m = '0; sim_m = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic shift_bit(input logic b, input logic is_ctrl);
    ce_n = 1'b0; rs = is_ctrl; din = b; sclk = 1'b1;
    if (is_ctrl) begin
      exp_q.push_back(sim_m ? b : ctl_m[7]);
      req_q.push_back(sim_m ? "R3 dout passthru" : "R2 dout serial");
    end else begin
      exp_q.push_back(dot_m[DOT-1]);
      req_q.push_back("R1 dout dot");
    end
    mon_en = 1'b1;
    step();
    mon_en = 1'b0; sclk = 1'b0;
    if (is_ctrl) ctl_m = {ctl_m[6:0], b};
    else         dot_m = {dot_m[DOT-2:0], b};
  endtask

  task automatic write_ctrl(input logic [7:0] w, input logic osc_at_rise);
    for (int i = 7; i >= 0; i--) shift_bit(w[i], 1'b1);
    ce_n = 1'b1; osc = osc_at_rise;
    if (osc_at_rise) begin
      @(negedge clk);
      check("R6 tick at latch", {{(DOT-1){1'b0}}, disp_tick}, {{(DOT-1){1'b0}}, 1'b1});
      @(posedge clk); #1;
    end else begin
      step();
    end
    osc = 1'b0;
    if (w[7]) sim_m = w[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R5 dot", dot, '0);
    check("R5 ctrl0", DOT'(c0), '0);
    check("R5 ctrl1", DOT'(c1), '0);
    check("R5 done", DOT'(done), '0);
    step();

    // dot chain, longer than the register
    for (int i = 0; i < 170; i++) shift_bit(((i * 5) % 7) < 3, 1'b0);
    ce_n = 1'b1; step();
    @(negedge clk);
    check("R1 dot_o", dot, dot_m);
    check("R4 dot-only rise keeps ctrl0", DOT'(c0), '0);
    check("R4 dot-only rise keeps ctrl1", DOT'(c1), '0);

    // strobes while deselected
    step();
    rs = 1'b0; din = 1'b1; sclk = 1'b1;
    repeat (4) step();
    rs = 1'b1; repeat (3) step();
    sclk = 1'b0; rs = 1'b0;
    @(negedge clk);
    check("R8 dot unchanged", dot, dot_m);
    step();

    write_ctrl(8'h5A, 1'b0);
    @(negedge clk);
    check("R4 ctrl0 load", DOT'(c0), DOT'(8'h5A));
    check("R4 ctrl1 untouched", DOT'(c1), '0);
    step();

    write_ctrl(8'h81, 1'b0);          // shifts out 5A serially
    @(negedge clk);
    check("R4 ctrl1 load", DOT'(c1), DOT'(8'h81));
    check("R4 ctrl0 kept", DOT'(c0), DOT'(8'h5A));
    step();

    write_ctrl(8'h3C, 1'b0);          // simultaneous mode passthru
    @(negedge clk);
    check("R4 ctrl0 in sim mode", DOT'(c0), DOT'(8'h3C));
    step();
    for (int i = 0; i < 6; i++) shift_bit(i[0], 1'b0);
    ce_n = 1'b1; step();

    // refresh, direct clock
    do_reset();
    for (int i = 0; i < 514; i++) begin
      osc = 1'b1;
      @(negedge clk);
      if (i < 4) check("R6 direct tick", DOT'(disp_tick), DOT'(1'b1));
      check("R7 refresh direct", DOT'(done), DOT'(i == 512));
      @(posedge clk); #1;
    end
    osc = 1'b0;

    // prescale set with a tick on the latch cycle
    do_reset();
    write_ctrl(8'h82, 1'b1);
    for (int k = 0; k < 4096; k++) begin
      osc = 1'b1;
      @(negedge clk);
      check("R6 prescale tick", DOT'(disp_tick), DOT'((k % 8) == 7));
      check("R7 refresh prescaled", DOT'(done), DOT'(k == 4088));
      @(posedge clk); #1;
    end
    osc = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule